// File: doc/BRIEF.md
# DDR2 Burst Column Sequencer

This block produces the column order of one DDR2 data burst for a memory controller. The controller gives it a start column, the burst length code from its mode-register image and the burst type bit. It then emits the column index of every data beat. Each controller clock carries two beats, one for the rising half and one for the falling half. The pair that closes the burst is flagged. A burst of four takes two clocks and a burst of eight takes four, which matches the two-clock minimum spacing of column commands.

Two orderings are supported, chosen per burst. In wrap order the low field counts upward from the start and wraps inside the aligned window of the burst. In XOR order the low field is the start field XORed with the beat number. Column bits above the burst field are copied unchanged from the start column. A length code other than the two legal ones is refused: the block raises a one-cycle error flag and emits nothing.

Top module: `ddr2_burst_col_seq`

## Requirements
- R1: A `start` pulse sampled while `busy` is low, with `len_code` 3'b010 (length 4) or 3'b011 (length 8), is accepted. `beat_valid` is high from the next cycle for 2 consecutive cycles (length 4) or 4 consecutive cycles (length 8), and `busy` follows `beat_valid`.
- R2: With `burst_xor` = 0, beat n (n = 0..BL-1) carries a low field equal to (start low field + n) mod BL. The low field is bits 1:0 for length 4 and bits 2:0 for length 8.
- R3: With `burst_xor` = 1, beat n carries a low field equal to the start low field XOR n.
- R4: Column bits above the low field (bits COL_W-1:2 for length 4, COL_W-1:3 for length 8) equal those of `start_col`. For length 4, start bit 2 therefore has no effect on the order.
- R5: In pair k (k counted from 0), `beat_col_rise` carries beat 2k and `beat_col_fall` carries beat 2k+1. `beat_last` is high on the final pair only.
- R6: `done` is high for exactly one cycle, the cycle after the final pair, and `beat_valid` is low in that cycle.
- R7: A `start` sampled while idle with any other `len_code` makes `cfg_err` high for one cycle, the next cycle. No pair is emitted.
- R8: A `start` sampled while `busy` is high is ignored. The running burst keeps its order and no further burst follows it.
- R9: After reset, `busy`, `beat_valid`, `beat_last`, `done` and `cfg_err` are low.
- R10: A `start` sampled in the `done` cycle is accepted. Its first pair follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to sequence one burst |
| start_col | input | COL_W | Start column address of the burst |
| len_code | input | 3 | Burst length code: 010 selects 4, 011 selects 8 |
| burst_xor | input | 1 | Burst order: 0 wrap, 1 XOR |
| busy | output | 1 | A burst is being emitted |
| beat_valid | output | 1 | The beat pair on the column outputs is valid |
| beat_col_rise | output | COL_W | Column of the rising-half beat |
| beat_col_fall | output | COL_W | Column of the falling-half beat |
| beat_last | output | 1 | The current pair closes the burst |
| done | output | 1 | One-cycle pulse after the final pair |
| cfg_err | output | 1 | One-cycle pulse after a refused length code |

## Verification
The embedded properties assume that `start` is a synchronous level sampled at the rising edge. They also assume that the start column, length code and order bit are stable in the cycle that `start` is accepted. Only values captured at acceptance are checked against the outputs. The bench changes inputs only on falling edges and returns `start` low after one cycle, except when it deliberately holds `start` high during a burst to test R8. Every start column from 0 to 7 is run with a fixed upper part, in both orders and at both lengths, next to refused codes and a start that follows directly on `done`.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic {
      ORD_WRAP = 1'b0,
      ORD_XOR  = 1'b1
   } burst_order_e;

   localparam logic [2:0] LEN_CODE_4 = 3'b010;
   localparam logic [2:0] LEN_CODE_8 = 3'b011;

   localparam int unsigned LANES    = 2;
   localparam int unsigned MAX_BEAT = 8;
   localparam int unsigned BEAT_W   = $clog2(MAX_BEAT);
   localparam int unsigned PAIR_W   = $clog2(MAX_BEAT / LANES);

   // low field of one beat; wide selects the 8-beat window
   function automatic logic [BEAT_W-1:0] beat_field(
      input logic [BEAT_W-1:0] base,
      input logic [BEAT_W-1:0] n,
      input logic              wide,
      input burst_order_e      ord
   );
      logic [BEAT_W-1:0] raw;
      logic [BEAT_W-1:0] mask;
      mask = wide ? 3'b111 : 3'b011;
      raw  = (ord == ORD_XOR) ? (base ^ n) : (base + n);
      return (raw & mask) | (base & ~mask);
   endfunction

endpackage

// File: rtl/bseq_len_decode.sv
module bseq_len_decode
   import burst_seq_pkg::*;
(
   input  logic [2:0]        code,
   output logic              legal,
   output logic              wide,
   output logic [PAIR_W-1:0] pairs_m1
);

   always_comb begin
      legal    = 1'b0;
      wide     = 1'b0;
      pairs_m1 = '0;
      unique case (code)
         LEN_CODE_4: begin
            legal    = 1'b1;
            pairs_m1 = PAIR_W'(4 / LANES - 1);
         end
         LEN_CODE_8: begin
            legal    = 1'b1;
            wide     = 1'b1;
            pairs_m1 = PAIR_W'(8 / LANES - 1);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bseq_pair_counter.sv
module bseq_pair_counter #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] last_idx,
   output logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             last,
   output logic             done
);

   logic [CNT_W-1:0] last_idx_q;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("bseq_pair_counter: CNT_W must be at least 1");
      end
   endgenerate

   assign last = run && (cnt == last_idx_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run        <= 1'b0;
         cnt        <= '0;
         last_idx_q <= '0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         if (run) begin
            if (cnt == last_idx_q) begin
               run  <= 1'b0;
               cnt  <= '0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (load) begin
            run        <= 1'b1;
            cnt        <= '0;
            last_idx_q <= last_idx;
         end
      end
   end

   AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= last_idx_q)); // R1

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (done && !run)); // R6

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_STEP_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !last) |=> (run && cnt == $past(cnt) + 1'b1)); // R8

endmodule

// File: rtl/bseq_lane_order.sv
module bseq_lane_order
   import burst_seq_pkg::*;
#(
   parameter int unsigned COL_W = 10,
   parameter int unsigned LANE  = 0
) (
   input  logic [COL_W-1:0]  base_col,
   input  logic [PAIR_W-1:0] pair_idx,
   input  logic              wide,
   input  burst_order_e      ord,
   output logic [COL_W-1:0]  col
);

   localparam int unsigned LANE_W = $clog2(LANES);

   logic [BEAT_W-1:0] beat_n;

   generate
      if (LANE >= LANES) begin : g_bad_lane
         $error("bseq_lane_order: LANE out of range");
      end
   endgenerate

   assign beat_n = {pair_idx, LANE_W'(LANE)};

   always_comb begin
      col              = base_col;
      col[BEAT_W-1:0]  = beat_field(base_col[BEAT_W-1:0], beat_n, wide, ord);
   end

endmodule

// File: rtl/ddr2_burst_col_seq.sv
module ddr2_burst_col_seq
   import burst_seq_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       len_code,
   input  logic             burst_xor,
   output logic             busy,
   output logic             beat_valid,
   output logic [COL_W-1:0] beat_col_rise,
   output logic [COL_W-1:0] beat_col_fall,
   output logic             beat_last,
   output logic             done,
   output logic             cfg_err
);

   generate
      if (COL_W < BEAT_W + 1) begin : g_bad_width
         $error("ddr2_burst_col_seq: COL_W too small for an 8-beat window");
      end
      if (LANES != 2) begin : g_bad_lanes
         $error("ddr2_burst_col_seq: two beats per clock expected");
      end
   endgenerate

   logic              code_ok;
   logic              code_wide;
   logic [PAIR_W-1:0] code_pairs_m1;
   logic              accept;
   logic              load;
   logic              run;
   logic [PAIR_W-1:0] pair_idx;
   logic              last;
   logic              done_int;
   logic [COL_W-1:0]  base_q;
   logic              wide_q;
   burst_order_e      ord_q;
   logic [COL_W-1:0]  lane_col [LANES];

   bseq_len_decode u_dec (
      .code     (len_code),
      .legal    (code_ok),
      .wide     (code_wide),
      .pairs_m1 (code_pairs_m1)
   );

   assign accept = start && !run;
   assign load   = accept && code_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         wide_q  <= 1'b0;
         ord_q   <= ORD_WRAP;
         cfg_err <= 1'b0;
      end else begin
         cfg_err <= accept && !code_ok;
         if (load) begin
            base_q <= start_col;
            wide_q <= code_wide;
            ord_q  <= burst_order_e'(burst_xor);
         end
      end
   end

   bseq_pair_counter #(.CNT_W(PAIR_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .last_idx (code_pairs_m1),
      .run      (run),
      .cnt      (pair_idx),
      .last     (last),
      .done     (done_int)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      bseq_lane_order #(.COL_W(COL_W), .LANE(g)) u_lane (
         .base_col (base_q),
         .pair_idx (pair_idx),
         .wide     (wide_q),
         .ord      (ord_q),
         .col      (lane_col[g])
      );
   end

   assign busy          = run;
   assign beat_valid    = run;
   assign beat_last     = last;
   assign done          = done_int;
   assign beat_col_rise = lane_col[0];
   assign beat_col_fall = lane_col[1];

   AST_ERR_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !beat_valid); // R7

   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> !cfg_err || $past(start)); // R7

   AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |-> beat_valid); // R5

   AST_WRAP_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && ord_q == ORD_WRAP) |->
         (((beat_col_fall[BEAT_W-1:0] - beat_col_rise[BEAT_W-1:0])
           & (wide_q ? 3'b111 : 3'b011)) == 3'd1)); // R2

   AST_XOR_PAIR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && ord_q == ORD_XOR) |->
         ((beat_col_rise ^ beat_col_fall) == COL_W'(1))); // R3

   AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |->
         (beat_col_rise[COL_W-1:BEAT_W] == base_q[COL_W-1:BEAT_W] &&
          beat_col_fall[COL_W-1:BEAT_W] == base_q[COL_W-1:BEAT_W] &&
          (wide_q || beat_col_rise[BEAT_W-1] == base_q[BEAT_W-1]))); // R4

   AST_FIRST_PAIR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> beat_valid); // R1

endmodule

// File: tb/ddr2_burst_col_seq_test.sv
`timescale 1ns/1ps
module ddr2_burst_col_seq_test;

   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic [2:0]       len_code = 3'b010;
   logic             burst_xor = 1'b0;
   logic             busy, beat_valid, beat_last, done, cfg_err;
   logic [COL_W-1:0] beat_col_rise, beat_col_fall;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ddr2_burst_col_seq #(.COL_W(COL_W)) uut (
      .clk, .rst_n, .start, .start_col, .len_code, .burst_xor,
      .busy, .beat_valid, .beat_col_rise, .beat_col_fall,
      .beat_last, .done, .cfg_err
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_col(input int s, input bit wide, input bit xo, input int n);
      int mask = wide ? 7 : 3;
      int low  = xo ? ((s ^ n) & mask) : ((s + n) & mask);
      return (s & ~mask) | low;
   endfunction

   // drives start for one cycle; leaves time at the negedge of the first pair
   task automatic launch(input int s, input bit wide, input bit xo);
      start_col = COL_W'(s);
      len_code  = wide ? 3'b011 : 3'b010;
      burst_xor = xo;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
   endtask

   // checks every pair of a running burst, optionally pokes start while busy
   task automatic expect_burst(input int s, input bit wide, input bit xo, input bit poke);
      int pairs = wide ? 4 : 2;
      for (int p = 0; p < pairs; p++) begin
         chk("R1 valid", beat_valid, 1);
         chk("R1 busy", busy, 1);
         chk(xo ? "R3 rise" : "R2 rise", beat_col_rise, exp_col(s, wide, xo, 2*p));
         chk(xo ? "R3 fall" : "R2 fall", beat_col_fall, exp_col(s, wide, xo, 2*p+1));
         chk("R5 last", beat_last, (p == pairs-1) ? 1 : 0);
         if (poke) begin
            start     = (p == 0);
            start_col = COL_W'(s ^ 3);
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk("R6 done", done, 1);
      chk("R6 valid low", beat_valid, 0);
   endtask

   task automatic t_reset();
      chk("R9 busy", busy, 0);
      chk("R9 valid", beat_valid, 0);
      chk("R9 last", beat_last, 0);
      chk("R9 done", done, 0);
      chk("R9 err", cfg_err, 0);
   endtask

   task automatic t_all_orders();
      for (int w = 0; w < 2; w++)
         for (int x = 0; x < 2; x++)
            for (int s = 0; s < 8; s++) begin
               launch(s | 10'h2A8, w[0], x[0]);
               expect_burst(s | 10'h2A8, w[0], x[0], 1'b0);
               @(negedge clk);
               chk("R6 done single", done, 0);
            end
   endtask

   task automatic t_bl4_bit2();
      // R4: start bit 2 kept and no effect on order for length 4
      launch(10'h005, 1'b0, 1'b0);
      chk("R4 rise", beat_col_rise, 10'h005);
      chk("R4 fall", beat_col_fall, 10'h006);
      @(negedge clk);
      chk("R4 rise2", beat_col_rise, 10'h007);
      chk("R4 fall2", beat_col_fall, 10'h004);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_bad_codes();
      for (int c = 0; c < 8; c++) begin
         if (c == 2 || c == 3) continue;
         len_code = 3'(c);
         start    = 1'b1;
         @(negedge clk);
         start    = 1'b0;
         chk("R7 err", cfg_err, 1);
         chk("R7 no valid", beat_valid, 0);
         @(negedge clk);
         chk("R7 err pulse", cfg_err, 0);
         chk("R7 still idle", beat_valid, 0);
      end
   endtask

   task automatic t_busy_start();
      launch(10'h1F5, 1'b1, 1'b1);
      expect_burst(10'h1F5, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      chk("R8 no extra burst", beat_valid, 0);
      chk("R8 busy", busy, 0);
   endtask

   task automatic t_back_to_back();
      launch(10'h002, 1'b0, 1'b1);
      expect_burst(10'h002, 1'b0, 1'b1, 1'b0);
      // now in the done cycle: start again
      launch(10'h0F3, 1'b1, 1'b0);
      chk("R10 accepted", beat_valid, 1);
      expect_burst(10'h0F3, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_all_orders();
      t_bl4_bit2();
      t_bad_codes();
      t_busy_start();
      t_back_to_back();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule